// File: doc/BRIEF.md
# Power-Transfer Termination and Source Arbiter

This block supervises a wireless power receiver. It watches a set of digitized condition flags and asks the packet modulator to send an end-power-transfer request, with an 8-bit reason code, whenever a terminating condition appears. The flags come from comparators: adapter present, control pin high, control pin low, thermistor hot, die overtemperature, current-limit resistor too low, and rectifier not converging. The modulator and the comparators sit outside the block.

The block also chooses the power source when a wired adapter is plugged in, based on a two-bit preference strap. When wired power is preferred, the block runs a timed handover. It first requests termination, then turns off the wireless output and releases the power-good line. It turns on the adapter switch once the power-good line is seen idle, or once a millisecond budget expires, whichever comes first.

At startup, a link-start pulse asks whether identification may begin. If a terminating condition is already active at that point, the block requests termination at once instead of allowing identification.

Top module: `ept_source_arbiter`

## Requirements
- R1: While reset is applied and after it is released, and before any flag is raised, the outputs are: ept_req=0, ept_code=0x00, ident_go=0, wl_out_en=1, adp_sw_en=0, pg_release=0.
- R2: A flag sampled high at a clock edge, after being low at the previous edge, makes ept_req high for exactly the following cycle. The code is taken from the flag:
  - ctrl_high gives 0x01.
  - die_hot or ilim_low gives 0x02.
  - ts_hot or ctrl_low gives 0x03.
  - rect_stuck gives 0x04.
  - adapter_present gives 0x00.
- R3: Each reason raises one request per rising edge of its condition. A condition held high raises no further requests. Two flags that share a code form one condition, which is their OR.
- R4: When several conditions rise at the same edge, one request is sent. Its code is the lowest of 0x01 to 0x04 among them. The adapter reason, 0x00, ranks behind all of these.
- R5: With pref_strap=01 (wireless preferred), adapter insertion sends no request. wl_out_en stays 1 and adp_sw_en stays 0.
- R6: With pref_strap=00 or 10 (wired preferred), adapter insertion sends a 0x00 request in the first cycle. In the next cycle, wl_out_en falls to 0 and pg_release rises to 1, while adp_sw_en is still 0.
- R7: During a handover, adp_sw_en rises in the cycle after pg_idle is sampled high. Otherwise it rises in the cycle after the HANDOVER_MS-th tick_ms counted in the handover. wl_out_en and adp_sw_en are never high together.
- R8: With pref_strap=11, adapter insertion sends a 0x00 request. While the adapter stays present, wl_out_en=0, adp_sw_en=0 and pg_release=1.
- R9: One cycle after adapter_present is sampled low, the outputs are wl_out_en=1, adp_sw_en=0 and pg_release=0.
- R10: A ping_start pulse with any eligible condition already active gives a request carrying the winning active code, and ident_go stays 0. With no condition active, it gives a one-cycle ident_go pulse and no request.
- R11: The strap is taken at adapter insertion. Changing pref_strap while the adapter stays present does not change wl_out_en, adp_sw_en or pg_release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| ping_start | input | 1 | Link start; asks whether identification may begin |
| adapter_present | input | 1 | Adapter voltage above threshold |
| ctrl_high | input | 1 | Control pin above its high threshold |
| ctrl_low | input | 1 | Control pin below its low threshold |
| ts_hot | input | 1 | Thermistor reports hot |
| die_hot | input | 1 | Die over temperature |
| ilim_low | input | 1 | Current-limit resistor too low |
| rect_stuck | input | 1 | Rectifier voltage not converging |
| pref_strap | input | 2 | Source preference strap |
| pg_idle | input | 1 | Power-good line observed released |
| ept_req | output | 1 | Termination request pulse |
| ept_code | output | 8 | Reason code of the last request |
| ident_go | output | 1 | Identification may proceed (pulse) |
| wl_out_en | output | 1 | Wireless output enable |
| adp_sw_en | output | 1 | Adapter switch enable |
| pg_release | output | 1 | Release wireless power-good |

## Verification
Most internal errors show at the ports within one or two cycles.
- A corrupted edge-detect register shows as a missing request, or a repeated request while a flag is held.
- A wrong source state shows as an illegal mix of wl_out_en, adp_sw_en and pg_release on the next cycle.
- A corrupted handover counter shows only at the end of the millisecond budget, as an adapter switch that closes one tick early or late. The bench therefore counts the ticks exactly.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam int COND_N = 5;
  localparam int CODE_W = 8;

  // condition ranks, lowest index wins
  localparam int RK_CHG = 0;
  localparam int RK_INT = 1;
  localparam int RK_HOT = 2;
  localparam int RK_OVV = 3;
  localparam int RK_ADP = 4;

  typedef enum logic [2:0] {
    SRC_WIRELESS = 3'd0,
    SRC_NOTIFY   = 3'd1,
    SRC_HANDOVER = 3'd2,
    SRC_WIRED    = 3'd3,
    SRC_NONE     = 3'd4
  } src_state_e;

  localparam logic [1:0] STRAP_WIRELESS = 2'b01;
  localparam logic [1:0] STRAP_NEITHER  = 2'b11;

  function automatic logic [CODE_W-1:0] rank_code(input int rk);
    if (rk == RK_ADP) rank_code = '0;
    else              rank_code = CODE_W'(rk + 1);
  endfunction
endpackage

// File: rtl/ept_rst_sync.sv
module ept_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/ept_cond_map.sv
module ept_cond_map
  import ept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adapter_present,
  input  logic              ctrl_high,
  input  logic              ctrl_low,
  input  logic              ts_hot,
  input  logic              die_hot,
  input  logic              ilim_low,
  input  logic              rect_stuck,
  output logic [COND_N-1:0] active,
  output logic [COND_N-1:0] rising
);
  logic [COND_N-1:0] prev_q;

  always_comb begin
    active         = '0;
    active[RK_CHG] = ctrl_high;
    active[RK_INT] = die_hot | ilim_low;
    active[RK_HOT] = ts_hot | ctrl_low;
    active[RK_OVV] = rect_stuck;
    active[RK_ADP] = adapter_present;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= active;
  end

  assign rising = active & ~prev_q;
endmodule

// File: rtl/ept_prio_sel.sv
module ept_prio_sel
  import ept_pkg::*;
#(
  parameter int N = COND_N
) (
  input  logic [N-1:0]      req,
  output logic              hit,
  output logic [CODE_W-1:0] code
);
  logic [N:0]   taken;
  logic [N-1:0] sel;

  assign taken[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rank
      assign sel[gi]     = req[gi] & ~taken[gi];
      assign taken[gi+1] = taken[gi] | req[gi];
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) code = code | rank_code(i);
    end
  end

  assign hit = taken[N];
endmodule

// File: rtl/ept_src_arb.sv
module ept_src_arb
  import ept_pkg::*;
#(
  parameter int HANDOVER_MS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       adp_level,
  input  logic       adp_rise,
  input  logic [1:0] pref_strap,
  input  logic       pg_idle,
  output logic       wl_out_en,
  output logic       adp_sw_en,
  output logic       pg_release
);
  localparam int CNT_W = $clog2(HANDOVER_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HANDOVER_MS - 1);

  src_state_e      state_q, state_d;
  logic            tgt_none_q, tgt_none_d, tgt_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            budget_out;

  assign budget_out = tick_ms && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    tgt_en  = 1'b0;
    unique case (state_q)
      SRC_WIRELESS: begin
        if (adp_rise && (pref_strap != STRAP_WIRELESS)) begin
          state_d = SRC_NOTIFY;
          tgt_en  = 1'b1;
        end
      end
      SRC_NOTIFY: begin
        if (!adp_level)      state_d = SRC_WIRELESS;
        else if (tgt_none_q) state_d = SRC_NONE;
        else                 state_d = SRC_HANDOVER;
      end
      SRC_HANDOVER: begin
        if (!adp_level)                 state_d = SRC_WIRELESS;
        else if (pg_idle || budget_out) state_d = SRC_WIRED;
      end
      SRC_WIRED, SRC_NONE: begin
        if (!adp_level) state_d = SRC_WIRELESS;
      end
      default: state_d = SRC_WIRELESS;
    endcase
  end

  assign tgt_none_d = (pref_strap == STRAP_NEITHER);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (state_q != SRC_HANDOVER) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_ms && !budget_out) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SRC_WIRELESS;
      tgt_none_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q <= state_d;
      if (tgt_en) tgt_none_q <= tgt_none_d;
      if (cnt_en) cnt_q      <= cnt_d;
    end
  end

  assign wl_out_en  = (state_q == SRC_WIRELESS) || (state_q == SRC_NOTIFY);
  assign adp_sw_en  = (state_q == SRC_WIRED);
  assign pg_release = (state_q == SRC_HANDOVER) || (state_q == SRC_WIRED) ||
                      (state_q == SRC_NONE);
endmodule

// File: rtl/ept_source_arbiter.sv
module ept_source_arbiter
  import ept_pkg::*;
#(
  parameter int HANDOVER_MS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              ping_start,
  input  logic              adapter_present,
  input  logic              ctrl_high,
  input  logic              ctrl_low,
  input  logic              ts_hot,
  input  logic              die_hot,
  input  logic              ilim_low,
  input  logic              rect_stuck,
  input  logic [1:0]        pref_strap,
  input  logic              pg_idle,
  output logic              ept_req,
  output logic [CODE_W-1:0] ept_code,
  output logic              ident_go,
  output logic              wl_out_en,
  output logic              adp_sw_en,
  output logic              pg_release
);
  logic              rst_n_sync;
  logic [COND_N-1:0] active, rising;
  logic [COND_N-1:0] elig_mask, fire_set;
  logic              fire;
  logic [CODE_W-1:0] fire_code;
  logic              req_q, req_d;
  logic [CODE_W-1:0] code_q;
  logic              ident_q, ident_d;

  ept_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ept_cond_map u_map (
    .clk             (clk),
    .rst_n           (rst_n_sync),
    .adapter_present (adapter_present),
    .ctrl_high       (ctrl_high),
    .ctrl_low        (ctrl_low),
    .ts_hot          (ts_hot),
    .die_hot         (die_hot),
    .ilim_low        (ilim_low),
    .rect_stuck      (rect_stuck),
    .active          (active),
    .rising          (rising)
  );

  always_comb begin
    elig_mask         = '1;
    elig_mask[RK_ADP] = (pref_strap != STRAP_WIRELESS);
    fire_set          = (ping_start ? active : rising) & elig_mask;
  end

  ept_prio_sel #(.N(COND_N)) u_sel (
    .req  (fire_set),
    .hit  (fire),
    .code (fire_code)
  );

  assign req_d   = fire;
  assign ident_d = ping_start && !fire;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      req_q   <= 1'b0;
      code_q  <= '0;
      ident_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      ident_q <= ident_d;
      if (fire) code_q <= fire_code;
    end
  end

  ept_src_arb #(.HANDOVER_MS(HANDOVER_MS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .tick_ms    (tick_ms),
    .adp_level  (adapter_present),
    .adp_rise   (rising[RK_ADP]),
    .pref_strap (pref_strap),
    .pg_idle    (pg_idle),
    .wl_out_en  (wl_out_en),
    .adp_sw_en  (adp_sw_en),
    .pg_release (pg_release)
  );

  assign ept_req  = req_q;
  assign ept_code = code_q;
  assign ident_go = ident_q;
endmodule

// File: rtl/ept_source_arbiter_chk.sv
module ept_source_arbiter_chk (
  input logic       clk,
  input logic       rst_n_sync,
  input logic       adapter_present,
  input logic [1:0] pref_strap,
  input logic       ept_req,
  input logic [7:0] ept_code,
  input logic       ident_go,
  input logic       wl_out_en,
  input logic       adp_sw_en,
  input logic       pg_release
);
  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ept_req |-> (ept_code <= 8'h04));

  assert_no_adapter_code_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ept_req && ept_code == 8'h00) |-> ($past(pref_strap) != 2'b01));

  assert_sources_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(wl_out_en && adp_sw_en));

  assert_release_before_switch_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(adp_sw_en) |-> $past(pg_release));

  assert_unplug_wireless_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $past(!adapter_present) |-> (wl_out_en && !adp_sw_en && !pg_release));

  assert_ident_or_ept_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ident_go |-> !ept_req);
endmodule

bind ept_source_arbiter ept_source_arbiter_chk u_chk (
  .clk             (clk),
  .rst_n_sync      (rst_n_sync),
  .adapter_present (adapter_present),
  .pref_strap      (pref_strap),
  .ept_req         (ept_req),
  .ept_code        (ept_code),
  .ident_go        (ident_go),
  .wl_out_en       (wl_out_en),
  .adp_sw_en       (adp_sw_en),
  .pg_release      (pg_release)
);

// File: tb/ept_source_arbiter_tb.sv
module ept_source_arbiter_tb;
  localparam int HMS = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_ms, ping_start, adapter_present, ctrl_high, ctrl_low;
  logic ts_hot, die_hot, ilim_low, rect_stuck, pg_idle;
  logic [1:0] pref_strap;
  logic ept_req, ident_go, wl_out_en, adp_sw_en, pg_release;
  logic [7:0] ept_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ept_source_arbiter #(.HANDOVER_MS(HMS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ping_start(ping_start),
    .adapter_present(adapter_present), .ctrl_high(ctrl_high), .ctrl_low(ctrl_low),
    .ts_hot(ts_hot), .die_hot(die_hot), .ilim_low(ilim_low), .rect_stuck(rect_stuck),
    .pref_strap(pref_strap), .pg_idle(pg_idle), .ept_req(ept_req), .ept_code(ept_code),
    .ident_go(ident_go), .wl_out_en(wl_out_en), .adp_sw_en(adp_sw_en),
    .pg_release(pg_release)
  );

  // {flags[6:0] = adp,chi,clo,ts,die,ilim,rect ; strap[1:0] ; exp_req ; exp_code[7:0]}
  localparam logic [17:0] VEC [0:10] = '{
    {7'b0100000, 2'b00, 1'b1, 8'h01},  // R2 control high
    {7'b0000100, 2'b00, 1'b1, 8'h02},  // R2 die hot
    {7'b0000010, 2'b00, 1'b1, 8'h02},  // R2 limit resistor low
    {7'b0001000, 2'b00, 1'b1, 8'h03},  // R2 thermistor
    {7'b0010000, 2'b00, 1'b1, 8'h03},  // R2 control low
    {7'b0000001, 2'b00, 1'b1, 8'h04},  // R2 rectifier
    {7'b1000000, 2'b00, 1'b1, 8'h00},  // R2 adapter
    {7'b1000000, 2'b01, 1'b0, 8'h00},  // R5 wireless preferred
    {7'b0100001, 2'b00, 1'b1, 8'h01},  // R4
    {7'b1001100, 2'b10, 1'b1, 8'h02},  // R4
    {7'b0001001, 2'b00, 1'b1, 8'h03}   // R4
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_flags(input logic [6:0] f);
    {adapter_present, ctrl_high, ctrl_low, ts_hot, die_hot, ilim_low, rect_stuck} = f;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int pulses;
    rst_n = 1'b0;
    tick_ms = 0; ping_start = 0; pg_idle = 0; pref_strap = 2'b00;
    set_flags(7'b0);
    repeat (3) step();
    chk(!ept_req && ept_code == 8'h00 && wl_out_en && !adp_sw_en && !pg_release && !ident_go,
        "R1 in reset", {ept_req, wl_out_en, adp_sw_en, pg_release}, 4'b0100);
    rst_n = 1'b1;
    repeat (4) step();
    chk(!ept_req && ept_code == 8'h00 && wl_out_en && !adp_sw_en && !pg_release && !ident_go,
        "R1 after reset", {ept_req, wl_out_en, adp_sw_en, pg_release}, 4'b0100);

    // table walk
    for (int i = 0; i < 11; i++) begin
      pref_strap = VEC[i][10:9];
      set_flags(VEC[i][17:11]);
      step();
      chk(ept_req == VEC[i][8], $sformatf("R2/R4/R5 vec%0d req", i), ept_req, VEC[i][8]);
      if (VEC[i][8])
        chk(ept_code == VEC[i][7:0], $sformatf("R2/R4 vec%0d code", i), ept_code, VEC[i][7:0]);
      if (VEC[i][10:9] == 2'b01)
        chk(wl_out_en && !adp_sw_en, "R5 source unchanged", {wl_out_en, adp_sw_en}, 2'b10);
      set_flags(7'b0);
      step(); step();
    end

    // R3: held condition gives one request
    pulses = 0;
    ctrl_high = 1;
    for (int i = 0; i < 6; i++) begin step(); pulses += ept_req; end
    chk(pulses == 1, "R3 held control high", pulses, 1);
    ctrl_low = 1; step(); step();
    ilim_low = 1; step();                 // die_hot low, ilim rises: group 0x02 rises
    chk(ept_req && ept_code == 8'h02, "R3 new edge", ept_code, 2);
    die_hot = 1; step();                  // same group already high: no request
    chk(!ept_req, "R3 merged condition", ept_req, 0);
    set_flags(7'b0); step(); step();

    // R6/R7 timeout path
    pref_strap = 2'b00; adapter_present = 1; step();
    chk(ept_req && ept_code == 8'h00 && wl_out_en, "R6 request first", {ept_req, wl_out_en}, 2'b11);
    step();
    chk(!wl_out_en && pg_release && !adp_sw_en, "R6 handover",
        {wl_out_en, pg_release, adp_sw_en}, 3'b010);
    for (int i = 0; i < HMS - 1; i++) begin tick_ms = 1; step(); tick_ms = 0; step(); end
    chk(!adp_sw_en, "R7 before budget", adp_sw_en, 0);
    tick_ms = 1; step(); tick_ms = 0;
    chk(adp_sw_en && !wl_out_en && pg_release, "R7 budget expiry", adp_sw_en, 1);

    // R11 strap change ignored
    pref_strap = 2'b01; step(); step();
    chk(adp_sw_en && !wl_out_en && pg_release, "R11 strap change", adp_sw_en, 1);

    // R9 removal
    adapter_present = 0; step();
    chk(wl_out_en && !adp_sw_en && !pg_release, "R9 unplug",
        {wl_out_en, adp_sw_en, pg_release}, 3'b100);

    // R7 pg_idle path
    pref_strap = 2'b10; adapter_present = 1; step(); step();
    chk(!adp_sw_en && pg_release, "R7 handover entered", pg_release, 1);
    step(); pg_idle = 1; step(); pg_idle = 0;
    chk(adp_sw_en && !wl_out_en, "R7 idle line", adp_sw_en, 1);
    adapter_present = 0; step(); step();

    // R8 neither source
    pref_strap = 2'b11; adapter_present = 1; step();
    chk(ept_req && ept_code == 8'h00, "R8 request", ept_code, 0);
    step(); pg_idle = 1;
    for (int i = 0; i < 4; i++) begin tick_ms = 1; step(); tick_ms = 0; step(); end
    pg_idle = 0;
    chk(!wl_out_en && !adp_sw_en && pg_release, "R8 no source",
        {wl_out_en, adp_sw_en, pg_release}, 3'b001);
    adapter_present = 0; step(); step();

    // R10 startup
    pref_strap = 2'b00;
    ping_start = 1; step(); ping_start = 0;
    chk(ident_go && !ept_req, "R10 clean start", {ident_go, ept_req}, 2'b10);
    step();
    chk(!ident_go, "R10 ident pulse width", ident_go, 0);
    ts_hot = 1; rect_stuck = 1; step(); step(); step();
    ping_start = 1; step(); ping_start = 0;
    chk(ept_req && ept_code == 8'h03 && !ident_go, "R10 blocked start", ept_code, 3);
    set_flags(7'b0); step(); step();

    finish_run();
  end
endmodule